// File: doc/BRIEF.md
# Banked Address Extender with Code/Data Split

This block widens the 16-bit logical address of a small CPU into an 18-bit physical address. It places two bank bits above the untouched logical address. The bank bits come from two software-loaded bank registers, one for code and one for data. The bus cycle type picks which register applies. Instruction fetches land in the code region and reads land in the data region. Any write lands in the data region, so code can never be overwritten through this path.

Software loads a bank register by asserting that register's select strobe together with the write strobe. The new value is taken from the low data bits. It is used from the next bus cycle on, which lets a program swap sections of code or data in and out at run time. When mapping is switched off, the bank bits are forced to zero, so the physical address equals the logical one. Two chip selects, one for the code memory and one for the data memory, follow the same steering. A region flag tells the memory system which of the two spaces is being addressed.

Top module: `bank_mapper`

## Requirements
- R1: The low 16 bits of `phys_addr` always equal `cpu_addr`, combinationally in the same cycle.
- R2: Reset (asynchronous assertion of `rst_n` low) clears both bank registers to 0, so that with mapping on every access maps to bank 0.
- R3: In a fetch cycle (`cyc_type` = 2'b01) with `cpu_wr` low, `phys_addr[17:16]` is the code bank and `code_region` is 1.
- R4: In a read cycle (`cyc_type` = 2'b10), `phys_addr[17:16]` is the data bank and `code_region` is 0. The idle cycle (`cyc_type` = 2'b00) also presents the data bank.
- R5: A write, meaning `cyc_type` = 2'b11 or `cpu_wr` high (including `cpu_wr` high during a fetch-type cycle), always uses the data bank, with `code_region` 0 and `code_cs` low.
- R6: With `map_en` low, `phys_addr[17:16]` is 0 whatever the bank registers hold.
- R7: At a rising clock edge with `cpu_wr` high, `code_bank_sel` high loads `cpu_wdata[1:0]` into the code bank and `data_bank_sel` high loads it into the data bank; both may load at once and `cpu_wdata[7:2]` is ignored. The new value appears only from the following cycle on; the loading cycle itself still uses the old one.
- R8: A bank select strobe without `cpu_wr` leaves both bank registers unchanged.
- R9: `code_cs` is high only in an active code access and `data_cs` only in an active data access. The two are never high together, and both are low in an idle cycle and whenever either bank select strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 16 | Logical address from the CPU |
| cpu_wdata | input | 8 | CPU write data; low 2 bits load a bank register |
| cpu_wr | input | 1 | Write strobe |
| cyc_type | input | 2 | Cycle type: 00 idle, 01 fetch, 10 read, 11 write |
| code_bank_sel | input | 1 | Select strobe for the code bank register |
| data_bank_sel | input | 1 | Select strobe for the data bank register |
| map_en | input | 1 | 1 = apply banks, 0 = identity mapping |
| phys_addr | output | 18 | Physical address: {bank, cpu_addr} |
| code_region | output | 1 | 1 when the access targets the code space |
| code_cs | output | 1 | Chip select for the code memory |
| data_cs | output | 1 | Chip select for the data memory |

## Verification
The translation is driven with fetches, reads, write-type cycles and a fetch cycle that carries the write strobe, each after the code and data banks have been loaded with different values. A wrong choice of register or a wrong region flag therefore shows up as a different physical address. Addresses at 0x0000, 0xFFFF and mixed patterns separate a dropped or shifted low bit from a wrong bank. Register loads are checked in the loading cycle and the cycle after, with one strobe, with both strobes at once, and with a strobe but no write strobe; this separates early take-effect, cross-loading and spurious loads. Mapping is also switched off, and reset is applied mid-run, to confirm the zero bank bits.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;

  // Bus cycle encodings presented by the CPU side.
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'b00,
    CYC_FETCH = 2'b01,
    CYC_READ  = 2'b10,
    CYC_WRITE = 2'b11
  } cyc_e;

  // Index of each bank register inside the register array.
  localparam int unsigned BANK_CODE = 0;
  localparam int unsigned BANK_DATA = 1;
  localparam int unsigned BANK_COUNT = 2;

  // Steering decision for one bus cycle.
  typedef struct packed {
    logic to_code;
    logic code_cs;
    logic data_cs;
  } steer_t;

endpackage

// File: rtl/bmap_rst_sync.sv
module bmap_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/bmap_bank_regs.sv
module bmap_bank_regs #(
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned NUM_BANKS = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr,
  input  logic [NUM_BANKS-1:0]            sel,
  input  logic [BANK_W-1:0]               wdata,
  output logic [NUM_BANKS-1:0][BANK_W-1:0] bank_q
);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic              load_en;
    logic [BANK_W-1:0] bank_d;

    // Next-state: load on strobe plus write, else hold.
    always_comb begin
      load_en = wr & sel[g];
      bank_d  = load_en ? wdata : bank_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_q[g] <= '0;
      end else begin
        bank_q[g] <= bank_d;
      end
    end

    // R7: a strobed write is visible from the next cycle
    a_r7_load_next: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel[g]) |=> (bank_q[g] == $past(wdata)));

    // R8: without the write strobe the register holds
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && sel[g]) |=> $stable(bank_q[g]));
  end

endmodule

// File: rtl/bmap_cycle_steer.sv
module bmap_cycle_steer
  import bank_map_pkg::*;
(
  input  cyc_e   cyc,
  input  logic   wr,
  input  logic   regsel,
  output steer_t steer
);

  logic is_write;
  logic active;
  logic mem_ok;

  always_comb begin
    is_write      = wr | (cyc == CYC_WRITE);
    active        = wr | (cyc != CYC_IDLE);
    mem_ok        = active & ~regsel;
    steer.to_code = (cyc == CYC_FETCH) & ~is_write;
    steer.code_cs = mem_ok &  steer.to_code;
    steer.data_cs = mem_ok & ~steer.to_code;
  end

endmodule

// File: rtl/bmap_addr_build.sv
module bmap_addr_build #(
  parameter int unsigned LADDR_W = 16,
  parameter int unsigned BANK_W  = 2,
  localparam int unsigned PADDR_W = LADDR_W + BANK_W
) (
  input  logic               to_code,
  input  logic               map_en,
  input  logic [BANK_W-1:0]  code_bank,
  input  logic [BANK_W-1:0]  data_bank,
  input  logic [LADDR_W-1:0] laddr,
  output logic [PADDR_W-1:0] paddr
);

  logic [BANK_W-1:0] bank_pick;
  logic [BANK_W-1:0] bank_out;

  always_comb begin
    bank_pick = to_code ? code_bank : data_bank;
    bank_out  = map_en ? bank_pick : '0;
    paddr     = {bank_out, laddr};
  end

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_map_pkg::*;
#(
  parameter int unsigned LADDR_W = 16,
  parameter int unsigned BANK_W  = 2,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned PADDR_W = LADDR_W + BANK_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  input  logic               cpu_wr,
  input  logic [1:0]         cyc_type,
  input  logic               code_bank_sel,
  input  logic               data_bank_sel,
  input  logic               map_en,
  output logic [PADDR_W-1:0] phys_addr,
  output logic               code_region,
  output logic               code_cs,
  output logic               data_cs
);

  logic                             rst_sync_n;
  logic [BANK_COUNT-1:0]            sel_vec;
  logic [BANK_COUNT-1:0][BANK_W-1:0] bank_q;
  steer_t                           steer;
  cyc_e                             cyc;
  logic                             unused_wdata_hi;

  assign cyc = cyc_e'(cyc_type);
  assign unused_wdata_hi = ^cpu_wdata[DATA_W-1:BANK_W];

  always_comb begin
    sel_vec            = '0;
    sel_vec[BANK_CODE] = code_bank_sel;
    sel_vec[BANK_DATA] = data_bank_sel;
  end

  bmap_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  bmap_bank_regs #(.BANK_W(BANK_W), .NUM_BANKS(BANK_COUNT)) u_regs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr     (cpu_wr),
    .sel    (sel_vec),
    .wdata  (cpu_wdata[BANK_W-1:0]),
    .bank_q (bank_q)
  );

  bmap_cycle_steer u_steer (
    .cyc    (cyc),
    .wr     (cpu_wr),
    .regsel (code_bank_sel | data_bank_sel),
    .steer  (steer)
  );

  bmap_addr_build #(.LADDR_W(LADDR_W), .BANK_W(BANK_W)) u_addr (
    .to_code   (steer.to_code),
    .map_en    (map_en),
    .code_bank (bank_q[BANK_CODE]),
    .data_bank (bank_q[BANK_DATA]),
    .laddr     (cpu_addr),
    .paddr     (phys_addr)
  );

  assign code_region = steer.to_code;
  assign code_cs     = steer.code_cs;
  assign data_cs     = steer.data_cs;

  // R1: logical bits pass straight through
  a_r1_low_pass: assert property (@(posedge clk) disable iff (!rst_sync_n)
    phys_addr[LADDR_W-1:0] == cpu_addr);

  // R3: fetches with mapping on carry the code bank
  a_r3_fetch_bank: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (map_en && cyc == CYC_FETCH && !cpu_wr) |-> (phys_addr[PADDR_W-1:LADDR_W] == bank_q[BANK_CODE]));

  // R5: writes never reach code space
  a_r5_write_data: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_wr || cyc == CYC_WRITE) |-> (!code_region && !code_cs));

  // R6: disabled mapping yields zero bank bits
  a_r6_identity: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !map_en |-> (phys_addr[PADDR_W-1:LADDR_W] == '0));

  // R9: chip selects exclusive and quiet during register access
  a_r9_cs_excl: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({code_cs, data_cs}));

  a_r9_regsel_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (code_bank_sel || data_bank_sel) |-> (!code_cs && !data_cs));

endmodule

// File: tb/tb_bank_mapper.sv
module tb_bank_mapper;

  logic        clk;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_wr;
  logic [1:0]  cyc_type;
  logic        code_bank_sel;
  logic        data_bank_sel;
  logic        map_en;
  logic [17:0] phys_addr;
  logic        code_region;
  logic        code_cs;
  logic        data_cs;

  int checks;
  int fails;
  bit done;

  bank_mapper dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cyc_type(cyc_type), .code_bank_sel(code_bank_sel),
    .data_bank_sel(data_bank_sel), .map_en(map_en), .phys_addr(phys_addr),
    .code_region(code_region), .code_cs(code_cs), .data_cs(data_cs)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic       csel;
    logic       dsel;
    logic       wr;
    logic [7:0] wd;
    logic [1:0] cyc;
    logic       en;
    logic [15:0] addr;
    logic [17:0] ephys;
    logic       ecs_code;
    logic       ecs_data;
    logic       eregion;
    logic [3:0] req;
  } vec_t;

  // cyc: 0 idle, 1 fetch, 2 read, 3 write
  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,8'h00,2'd1,1'b1,16'h1234,18'h01234,1'b1,1'b0,1'b1,4'd2}, // R2 fetch bank 0
    '{1'b0,1'b0,1'b0,8'h00,2'd2,1'b1,16'hABCD,18'h0ABCD,1'b0,1'b1,1'b0,4'd2}, // R2 read bank 0
    '{1'b1,1'b0,1'b1,8'hF2,2'd3,1'b1,16'h0010,18'h00010,1'b0,1'b0,1'b0,4'd7}, // R7 load code=2, old value used
    '{1'b0,1'b0,1'b0,8'h00,2'd1,1'b1,16'h4000,18'h24000,1'b1,1'b0,1'b1,4'd3}, // R3 code bank 2
    '{1'b0,1'b0,1'b0,8'h00,2'd2,1'b1,16'h4000,18'h04000,1'b0,1'b1,1'b0,4'd4}, // R4 data bank still 0
    '{1'b0,1'b1,1'b1,8'h03,2'd3,1'b1,16'hFFFF,18'h0FFFF,1'b0,1'b0,1'b0,4'd7}, // R7 load data=3
    '{1'b0,1'b0,1'b0,8'h00,2'd2,1'b1,16'hFFFF,18'h3FFFF,1'b0,1'b1,1'b0,4'd1}, // R1 R4 top address
    '{1'b0,1'b0,1'b1,8'h00,2'd3,1'b1,16'h8001,18'h38001,1'b0,1'b1,1'b0,4'd5}, // R5 write cycle
    '{1'b0,1'b0,1'b1,8'h00,2'd1,1'b1,16'h0002,18'h30002,1'b0,1'b1,1'b0,4'd5}, // R5 strobe during fetch
    '{1'b0,1'b0,1'b0,8'h00,2'd1,1'b1,16'h0002,18'h20002,1'b1,1'b0,1'b1,4'd3}, // R3
    '{1'b0,1'b0,1'b0,8'h00,2'd1,1'b0,16'h0002,18'h00002,1'b1,1'b0,1'b1,4'd6}, // R6 fetch unmapped
    '{1'b0,1'b0,1'b0,8'h00,2'd2,1'b0,16'hC000,18'h0C000,1'b0,1'b1,1'b0,4'd6}, // R6 read unmapped
    '{1'b1,1'b0,1'b0,8'h01,2'd0,1'b1,16'h0000,18'h30000,1'b0,1'b0,1'b0,4'd9}, // R9 idle, select only
    '{1'b0,1'b0,1'b0,8'h00,2'd1,1'b1,16'h0000,18'h20000,1'b1,1'b0,1'b1,4'd8}, // R8 code unchanged
    '{1'b1,1'b1,1'b1,8'hFD,2'd3,1'b1,16'h0000,18'h30000,1'b0,1'b0,1'b0,4'd7}, // R7 both load 1
    '{1'b0,1'b0,1'b0,8'h00,2'd1,1'b1,16'h0055,18'h10055,1'b1,1'b0,1'b1,4'd7}, // R7 code=1
    '{1'b0,1'b0,1'b0,8'h00,2'd2,1'b1,16'h0055,18'h10055,1'b0,1'b1,1'b0,4'd7}, // R7 data=1
    '{1'b0,1'b1,1'b0,8'h02,2'd2,1'b1,16'h0007,18'h10007,1'b0,1'b0,1'b0,4'd9}, // R9 select mutes cs
    '{1'b0,1'b0,1'b0,8'h00,2'd2,1'b1,16'h0007,18'h10007,1'b0,1'b1,1'b0,4'd8}, // R8 data unchanged
    '{1'b0,1'b0,1'b0,8'h00,2'd0,1'b1,16'h0001,18'h10001,1'b0,1'b0,1'b0,4'd9}  // R9 idle no cs
  };

  task automatic drive(input vec_t v);
    code_bank_sel = v.csel;
    data_bank_sel = v.dsel;
    cpu_wr        = v.wr;
    cpu_wdata     = v.wd;
    cyc_type      = v.cyc;
    map_en        = v.en;
    cpu_addr      = v.addr;
  endtask

  task automatic check(input string tag, input logic [17:0] ephys,
                       input logic ec, input logic ed, input logic er);
    checks++;
    if (phys_addr !== ephys || code_cs !== ec || data_cs !== ed || code_region !== er) begin
      fails++;
      $display("FAIL %s: phys=%h cs_code=%b cs_data=%b region=%b expected phys=%h cs_code=%b cs_data=%b region=%b",
               tag, phys_addr, code_cs, data_cs, code_region, ephys, ec, ed, er);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    checks = 0;
    fails  = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    drive('{1'b0,1'b0,1'b0,8'h00,2'd1,1'b1,16'h0ABC,18'h0,1'b0,1'b0,1'b0,4'd0});
    @(negedge clk);
    #5 check("R2 in reset", 18'h00ABC, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      #5 check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].ephys,
               VECS[i].ecs_code, VECS[i].ecs_data, VECS[i].eregion);
    end

    // R2: mid-run reset clears both banks (both were 1)
    @(negedge clk);
    rst_n = 1'b0;
    drive('{1'b0,1'b0,1'b0,8'h00,2'd2,1'b1,16'h1111,18'h0,1'b0,1'b0,1'b0,4'd0});
    #5 check("R2 mid-run reset data", 18'h01111, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    drive('{1'b0,1'b0,1'b0,8'h00,2'd1,1'b1,16'h2222,18'h0,1'b0,1'b0,1'b0,4'd0});
    #5 check("R2 after reset code", 18'h02222, 1'b1, 1'b0, 1'b1);

    // R7: write-cycle load with upper data bits set, seen the cycle after
    @(negedge clk);
    drive('{1'b1,1'b0,1'b1,8'hAB,2'd3,1'b1,16'h0000,18'h0,1'b0,1'b0,1'b0,4'd0});
    #5 check("R7 load cycle", 18'h00000, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    drive('{1'b0,1'b0,1'b0,8'h00,2'd1,1'b1,16'h5A5A,18'h0,1'b0,1'b0,1'b0,4'd0});
    #5 check("R7 next cycle code=3", 18'h35A5A, 1'b1, 1'b0, 1'b1);

    @(negedge clk);
    finish_run();
  end

endmodule